// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three 8-bit parallel ports, called A, B and C, through a small byte-wide bus. The bus has an active-low chip select, active-low read and write strobes, a 2-bit register address, and separate input and output data buses. Each port has an output latch, an input-sampling register and per-pin output enables. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction.

Software uses one control address for two commands, and data bit 7 picks which one. With bit 7 set, the byte is a configuration word. It sets the four port directions and the group modes, and it clears every output latch. With bit 7 clear, the byte changes a single port C latch bit and leaves the other seven alone. Only plain, unhandshaked transfers are carried out. The strobed and bidirectional group modes are decoded and held on mode outputs, but they do not change pin behaviour.

A write takes effect after the write strobe's rising edge has been synchronised into the system clock domain. A read is combinational and is valid while chip select and read strobe are both low.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset every port is an input: all output enables are 0, both group mode outputs are 0, and all output latches are 0.
- R2: With chip select low, a write to address 0, 1 or 2 loads the port A, B or C output latch with the data byte. The write takes effect a fixed number of clocks after the write strobe rises.
- R3: A write to address 3 with data bit 7 = 1 sets the directions, where 1 means input and 0 means output. Bit 4 sets port A, bit 1 sets port B, bit 3 sets the port C upper nibble and bit 0 sets the port C lower nibble.
- R4: A configuration word (address 3, bit 7 = 1) clears the port A, B and C output latches to zero.
- R5: A write to address 3 with bit 7 = 0 loads port C latch bit n with data bit 0, where n is the binary value of data bits 3:1. Data bits 6:4 are ignored, and the other seven latch bits keep their values.
- R6: The single-bit command works on all eight port C bits, in any group mode and whatever the direction of the nibble that holds the bit.
- R7: In a configuration word, bits 6:5 give the group A mode on `grp_a_mode`: 00 gives 0, 01 gives 1, and 10 or 11 gives 2 (code 2'b10). Bit 2 gives the group B mode on `grp_b_mode`.
- R8: Reading address 0, 1 or 2 returns the output latch for a port or nibble set as an output, and the registered pin sample for a port or nibble set as an input.
- R9: `dout` is zero while chip select or read strobe is high. A read of address 3 returns zero.
- R10: A write strobe given while chip select is high changes no latch and no configuration.
- R11: The per-pin output enable of a port or nibble is 1 exactly when that port or nibble is set as an output. The two port C nibbles are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; committed on its rising edge |
| addr | input | 2 | Register select: 0 port A, 1 port B, 2 port C, 3 control |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin output enable |
| grp_a_mode | output | 2 | Stored group A mode |
| grp_b_mode | output | 1 | Stored group B mode |

## Verification
The bench builds the block with `SYNC_STAGES = 3` instead of the default 2. A deeper synchroniser shows that commit timing follows the parameter, and that the capture of address and data still holds after the strobe is released. Port width stays at its default of 8, which brings all eight single-bit targets within reach, together with the split-nibble read path on port C. The configurations used cover all-output, all-input, split port C, group mode 1 and both mode 2 encodings.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

  localparam int PW = 8;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  // Turn a configuration byte into the stored configuration fields.
  function automatic cfg_t decode_cfg(input logic [7:0] w);
    cfg_t c;
    c.a_mode = w[6] ? 2'b10 : {1'b0, w[5]};
    c.a_in   = w[4];
    c.cu_in  = w[3];
    c.b_mode = w[2];
    c.b_in   = w[1];
    c.cl_in  = w[0];
    return c;
  endfunction

  // Change the one port C latch bit picked by the command byte.
  function automatic logic [7:0] bsr_apply(input logic [7:0] cur,
                                           input logic [7:0] w);
    logic [7:0] r;
    r = cur;
    r[w[3:1]] = w[0];
    return r;
  endfunction

  // Choose, for each nibble, the latch or the pin sample as read data.
  function automatic logic [7:0] port_view(input logic [7:0] lat,
                                           input logic [7:0] pin,
                                           input logic hi_in,
                                           input logic lo_in);
    logic [7:0] v;
    v[7:4] = hi_in ? pin[7:4] : lat[7:4];
    v[3:0] = lo_in ? pin[3:0] : lat[3:0];
    return v;
  endfunction

endpackage

// File: rtl/ppio_wr_sync.sv
module ppio_wr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic       commit,
  output logic [1:0] c_addr,
  output logic [7:0] c_data
);

  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NS-1:0] sync_q;
  logic          wr_s;
  logic          wr_prev;
  logic          cap_cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[NS-2:0], wr_n};
  end

  assign wr_s = sync_q[NS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev  <= 1'b1;
      cap_cs_n <= 1'b1;
      c_addr   <= '0;
      c_data   <= '0;
    end else begin
      wr_prev <= wr_s;
      if (!wr_s) begin
        cap_cs_n <= cs_n;
        c_addr   <= addr;
        c_data   <= din;
      end
    end
  end

  assign commit = wr_s & ~wr_prev & ~cap_cs_n;

  // R2
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

endmodule

// File: rtl/ppio_cfg_reg.sv
module ppio_cfg_reg
  import ppio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [1:0] c_addr,
  input  logic [7:0] c_data,
  output cfg_t       cfg,
  output logic       mode_wr,
  output logic       bsr_wr
);

  logic ctl_hit;

  assign ctl_hit = commit && (sel_e'(c_addr) == SEL_CTL);
  assign mode_wr = ctl_hit &&  c_data[7];
  assign bsr_wr  = ctl_hit && !c_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg <= CFG_RESET;
    else if (mode_wr) cfg <= decode_cfg(c_data);
  end

  // R3
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (cfg.a_in == $past(c_data[4]) && cfg.b_in == $past(c_data[1])
                 && cfg.cu_in == $past(c_data[3]) && cfg.cl_in == $past(c_data[0])));

  // R7
  grp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (cfg.b_mode == $past(c_data[2]) && cfg.a_mode != 2'b11
                 && cfg.a_mode[1] == $past(c_data[6])));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg));

endmodule

// File: rtl/ppio_latches.sv
module ppio_latches
  import ppio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [1:0] c_addr,
  input  logic [7:0] c_data,
  input  logic       mode_wr,
  input  logic       bsr_wr,
  output logic [7:0] lat_a,
  output logic [7:0] lat_b,
  output logic [7:0] lat_c
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (mode_wr) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (bsr_wr) begin
      lat_c <= bsr_apply(lat_c, c_data);
    end else if (commit) begin
      case (sel_e'(c_addr))
        SEL_A:   lat_a <= c_data;
        SEL_B:   lat_b <= c_data;
        SEL_C:   lat_c <= c_data;
        default: ;
      endcase
    end
  end

  // R4
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (lat_a == '0 && lat_b == '0 && lat_c == '0));

  // R5
  bsr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> ((($past(lat_c) ^ lat_c) & ~(8'h01 << $past(c_data[3:1]))) == 8'h00));

  // R5
  bsr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> (lat_c[$past(c_data[3:1])] == $past(c_data[0])));

  // R2
  port_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && c_addr == 2'd0) |=> (lat_a == $past(c_data)));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(lat_a) && $stable(lat_b) && $stable(lat_c)));

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe,
  output logic [1:0] grp_a_mode,
  output logic       grp_b_mode
);

  localparam int HALF = PW / 2;

  logic       commit;
  logic [1:0] c_addr;
  logic [7:0] c_data;
  cfg_t       cfg;
  logic       mode_wr;
  logic       bsr_wr;
  logic [7:0] lat_a, lat_b, lat_c;
  logic [7:0] smp_a, smp_b, smp_c;
  logic       rd_act;

  ppio_wr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .din(din), .commit(commit), .c_addr(c_addr), .c_data(c_data)
  );

  ppio_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .commit(commit), .c_addr(c_addr),
    .c_data(c_data), .cfg(cfg), .mode_wr(mode_wr), .bsr_wr(bsr_wr)
  );

  ppio_latches u_lat (
    .clk(clk), .rst_n(rst_n), .commit(commit), .c_addr(c_addr),
    .c_data(c_data), .mode_wr(mode_wr), .bsr_wr(bsr_wr),
    .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_a <= '0;
      smp_b <= '0;
      smp_c <= '0;
    end else begin
      smp_a <= pa_in;
      smp_b <= pb_in;
      smp_c <= pc_in;
    end
  end

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;
  assign pa_oe  = {PW{~cfg.a_in}};
  assign pb_oe  = {PW{~cfg.b_in}};
  assign pc_oe  = {{HALF{~cfg.cu_in}}, {HALF{~cfg.cl_in}}};
  assign grp_a_mode = cfg.a_mode;
  assign grp_b_mode = cfg.b_mode;

  assign rd_act = !cs_n && !rd_n;

  always_comb begin
    dout = '0;
    if (rd_act) begin
      case (sel_e'(addr))
        SEL_A:   dout = port_view(lat_a, smp_a, cfg.a_in, cfg.a_in);
        SEL_B:   dout = port_view(lat_b, smp_b, cfg.b_in, cfg.b_in);
        SEL_C:   dout = port_view(lat_c, smp_c, cfg.cu_in, cfg.cl_in);
        default: dout = '0;
      endcase
    end
  end

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (dout == 8'h00));

  // R9
  ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && addr == 2'd3) |-> (dout == 8'h00));

  // R11
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pa_oe[0] == ~$past(c_data[4]) && pc_oe[7] == ~$past(c_data[3])
                 && pc_oe[0] == ~$past(c_data[0]) && pb_oe[0] == ~$past(c_data[1])));

endmodule

// File: tb/ppio_ctrl_tb.sv
module ppio_ctrl_tb;

  localparam int SYNC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [1:0] grp_a_mode;
  logic       grp_b_mode;

  always #4 clk = ~clk;

  ppio_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
  );

  // Observables: 0 dout, 1 pa_oe, 2 pb_oe, 3 pc_oe, 4 pa_out, 5 pb_out,
  // 6 pc_out, 7 {grp_a_mode, grp_b_mode}
  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  function automatic logic [7:0] observe(input int k);
    case (k)
      0: return dout;
      1: return pa_oe;
      2: return pb_oe;
      3: return pc_oe;
      4: return pa_out;
      5: return pb_out;
      6: return pc_out;
      default: return {5'b0, grp_a_mode, grp_b_mode};
    endcase
  endfunction

  // Monitor: pops expected items and compares them with the observables.
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        act = observe(it.kind);
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: observable %0d actual %02h expected %02h",
                   it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int k, input logic [7:0] e, input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                           input logic sel_n);
    @(negedge clk);
    addr = a; din = d; cs_n = sel_n; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_check(input logic [1:0] a, input logic [7:0] e,
                            input string tag);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1;
    expect_val(0, e, tag);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic check_now(input int k, input logic [7:0] e, input string tag);
    @(negedge clk);
    expect_val(k, e, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_now(1, 8'h00, "R1 pa_oe");
    check_now(2, 8'h00, "R1 pb_oe");
    check_now(3, 8'h00, "R1 pc_oe");
    check_now(7, 8'h00, "R1 modes");
    check_now(6, 8'h00, "R1 pc latch");
    // R9 idle bus and control read
    check_now(0, 8'h00, "R9 idle dout");
    read_check(2'd3, 8'h00, "R9 control read");
    // R8 input reads pins
    read_check(2'd0, 8'h5A, "R8 port A input");

    // R3 / R11 all outputs
    bus_write(2'd3, 8'h80, 1'b0);
    check_now(1, 8'hFF, "R11 pa_oe out");
    check_now(2, 8'hFF, "R11 pb_oe out");
    check_now(3, 8'hFF, "R3 pc_oe out");
    bus_write(2'd0, 8'h11, 1'b0);
    bus_write(2'd1, 8'h22, 1'b0);
    bus_write(2'd2, 8'h33, 1'b0);
    check_now(4, 8'h11, "R2 port A latch");
    check_now(5, 8'h22, "R2 port B latch");
    check_now(6, 8'h33, "R2 port C latch");
    read_check(2'd0, 8'h11, "R8 port A output read");
    read_check(2'd1, 8'h22, "R8 port B output read");

    // R5 single-bit commands
    bus_write(2'd3, 8'h0F, 1'b0);
    check_now(6, 8'hB3, "R5 set bit 7");
    bus_write(2'd3, 8'h78, 1'b0);
    check_now(6, 8'hA3, "R5 clear bit 4, bits 6:4 ignored");
    bus_write(2'd3, 8'h05, 1'b0);
    check_now(6, 8'hA7, "R5 set bit 2");
    check_now(4, 8'h11, "R5 port A untouched");

    // R10 write without chip select
    bus_write(2'd0, 8'hFF, 1'b1);
    check_now(4, 8'h11, "R10 deselected write to A");
    bus_write(2'd3, 8'h9B, 1'b1);
    check_now(1, 8'hFF, "R10 deselected config");

    // R4 latches cleared, port C fully input
    bus_write(2'd3, 8'h89, 1'b0);
    check_now(4, 8'h00, "R4 A cleared");
    check_now(5, 8'h00, "R4 B cleared");
    check_now(6, 8'h00, "R4 C cleared");
    check_now(3, 8'h00, "R3 pc_oe input");
    read_check(2'd2, 8'h96, "R8 port C input");

    // R11 split nibbles, R6 command on input nibble
    bus_write(2'd3, 8'h81, 1'b0);
    check_now(3, 8'hF0, "R11 split pc_oe");
    bus_write(2'd3, 8'h0D, 1'b0);
    check_now(6, 8'h40, "R6 set bit 6");
    bus_write(2'd3, 8'h03, 1'b0);
    check_now(6, 8'h42, "R6 set bit 1 on input nibble");
    read_check(2'd2, 8'h46, "R8 split nibble read");

    // R7 group modes, R6 in mode 1
    bus_write(2'd3, 8'hB6, 1'b0);
    check_now(7, 8'h03, "R7 modes A1 B1");
    check_now(1, 8'h00, "R3 A input");
    check_now(2, 8'h00, "R3 B input");
    check_now(3, 8'hFF, "R3 C output");
    bus_write(2'd3, 8'h07, 1'b0);
    check_now(6, 8'h08, "R6 set bit 3 in mode 1");
    read_check(2'd1, 8'hC3, "R8 port B input");
    pa_in = 8'h3C;
    read_check(2'd0, 8'h3C, "R8 port A new pins");
    bus_write(2'd3, 8'hC0, 1'b0);
    check_now(7, 8'h04, "R7 mode 2 code 10");
    bus_write(2'd3, 8'hE4, 1'b0);
    check_now(7, 8'h05, "R7 mode 2 code 11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule